// File: doc/BRIEF.md
# Parallel Predicate Compare Unit

This block holds a file of one-bit predicates and applies the predicate writes of several compare operations issued in the same cycle. Each issue lane carries two integer operands, a relation, a deferred-exception (NaT) flag per operand, a qualifying predicate index, two target predicate indices and a compare type. The lane evaluates the relation, folds in the NaT flags and the qualifying predicate, and decides which targets receive which value.

The parallel types (AND, OR and the two complementary forms) write only when the outcome settles the combined condition. Several of them can therefore aim at one predicate pair in a single cycle and still combine into the value a serial chain of compares would leave. Writes from all lanes are merged per predicate and land in the file at the next clock edge. The whole file is visible on one output vector.

Top module: `pcmp_unit`

## Requirements
- R1: After reset every predicate reads 0 except predicate 0, which reads 1.
- R2: Relation codes are EQ=0, NE=1, LT signed=2, LT unsigned=3. A normal compare (type 0) with a true qualifying predicate and no NaT writes the result to the first target and its complement to the second. Type codes 6 and 7 write nothing.
- R3: An unconditional compare (type 1) always writes both targets: result and complement when the qualifying predicate is true, and 0 to both when it is false.
- R4: A normal or unconditional compare with either operand NaT flag set writes 0 to both targets whenever it writes.
- R5: An AND compare (type 2) with a false result writes 0 to both targets. A true result leaves both unchanged.
- R6: An OR compare (type 3) with a true result writes 1 to both targets. A false result leaves both unchanged.
- R7: The AND-with-OR-complement compare (type 4) with a false result writes 0 to the first target and 1 to the second. The OR-with-AND-complement compare (type 5) with a true result writes 1 to the first and 0 to the second. The other outcome of each leaves both unchanged.
- R8: For the parallel types 2 to 5, a set NaT flag on either operand makes the result count as false.
- R9: With a false qualifying predicate, normal and parallel compares write nothing.
- R10: Writes from all lanes in one cycle combine per predicate. A predicate written both 0 and 1 in the same cycle becomes 0.
- R11: Predicate 0 always reads 1, and writes to it are ignored.
- R12: A lane reads its qualifying predicate as it stood before the current cycle's writes. Updates appear on the output one clock after issue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | LANES | Per-lane issue valid |
| op_type | input | 3*LANES | Per-lane compare type code |
| op_rel | input | 2*LANES | Per-lane relation code |
| op_qp | input | IDX_W*LANES | Per-lane qualifying predicate index |
| op_p1 | input | IDX_W*LANES | Per-lane first target index |
| op_p2 | input | IDX_W*LANES | Per-lane second target index |
| op_a | input | DATA_W*LANES | Per-lane first operand |
| op_b | input | DATA_W*LANES | Per-lane second operand |
| op_nat_a | input | LANES | Per-lane NaT flag of first operand |
| op_nat_b | input | LANES | Per-lane NaT flag of second operand |
| pred_o | output | NPRED | Current predicate file contents |

## Verification
The bench builds the unit with three lanes, 8-bit operands and the full 64-entry file. Three lanes make it possible to accumulate three parallel compares into one pair, and to create conflicts between normal compares and qualifying-predicate reads of a predicate that another lane writes in the same cycle. Narrow operands make equality, signed wrap-around and unsigned-versus-signed disagreement common under random stimulus. Random target indices are drawn from the low sixteen predicates so that lanes collide often.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;

    typedef enum logic [2:0] {
        CT_NORM    = 3'd0,
        CT_UNC     = 3'd1,
        CT_AND     = 3'd2,
        CT_OR      = 3'd3,
        CT_ANDORCM = 3'd4,
        CT_ORANDCM = 3'd5,
        CT_RSV6    = 3'd6,
        CT_RSV7    = 3'd7
    } ctype_e;

    typedef enum logic [1:0] {
        RL_EQ  = 2'd0,
        RL_NE  = 2'd1,
        RL_LT  = 2'd2,
        RL_LTU = 2'd3
    } rel_e;

    // write request of one lane towards its two targets
    typedef struct packed {
        logic we1;
        logic v1;
        logic we2;
        logic v2;
    } pwr_t;

endpackage

// File: rtl/pcmp_compare.sv
module pcmp_compare
    import pcmp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  rel_e              rel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              hit
);

    always_comb begin
        case (rel)
            RL_EQ:   hit = (a == b);
            RL_NE:   hit = (a != b);
            RL_LT:   hit = ($signed(a) < $signed(b));
            default: hit = (a < b);
        endcase
    end

endmodule

// File: rtl/pcmp_lane.sv
module pcmp_lane
    import pcmp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  ctype_e            ctype,
    input  rel_e              rel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              nat,
    input  logic              qp_val,
    output pwr_t              wr
);

    logic hit;
    logic res;      // result with NaT folded in as false
    logic res_n;    // complement, also forced low by NaT for normal forms
    logic live;

    pcmp_compare #(.DATA_W(DATA_W)) cmp_i (
        .rel (rel),
        .a   (a),
        .b   (b),
        .hit (hit)
    );

    assign res   = hit & ~nat;
    assign res_n = ~hit & ~nat;
    assign live  = valid & qp_val;

    always_comb begin
        wr = '0;
        case (ctype)
            CT_NORM: begin
                if (live) begin
                    wr.we1 = 1'b1;
                    wr.v1  = res;
                    wr.we2 = 1'b1;
                    wr.v2  = res_n;
                end
            end
            CT_UNC: begin
                if (valid) begin
                    wr.we1 = 1'b1;
                    wr.v1  = qp_val & res;
                    wr.we2 = 1'b1;
                    wr.v2  = qp_val & res_n;
                end
            end
            CT_AND: begin
                if (live && !res) begin
                    wr.we1 = 1'b1;
                    wr.we2 = 1'b1;
                end
            end
            CT_OR: begin
                if (live && res) begin
                    wr = '{we1: 1'b1, v1: 1'b1, we2: 1'b1, v2: 1'b1};
                end
            end
            CT_ANDORCM: begin
                if (live && !res) begin
                    wr = '{we1: 1'b1, v1: 1'b0, we2: 1'b1, v2: 1'b1};
                end
            end
            CT_ORANDCM: begin
                if (live && res) begin
                    wr = '{we1: 1'b1, v1: 1'b1, we2: 1'b1, v2: 1'b0};
                end
            end
            default: wr = '0;
        endcase
    end

    assert_and_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ctype == CT_AND && (wr.we1 || wr.we2)) |-> (!wr.v1 && !wr.v2));

    assert_or_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ctype == CT_OR && (wr.we1 || wr.we2)) |-> (wr.v1 && wr.v2));

    assert_unc_always_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ctype == CT_UNC) |-> (wr.we1 && wr.we2));

    assert_nat_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && nat && (ctype == CT_NORM || ctype == CT_UNC)) |-> (!wr.v1 && !wr.v2));

    assert_qp_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!qp_val && ctype != CT_UNC) |-> (!wr.we1 && !wr.we2));

endmodule

// File: rtl/pcmp_merge.sv
module pcmp_merge
    import pcmp_pkg::*;
#(
    parameter int LANES = 2,
    parameter int NPRED = 64,
    localparam int IDX_W = $clog2(NPRED)
) (
    input  pwr_t             wr   [LANES],
    input  logic [IDX_W-1:0] idx1 [LANES],
    input  logic [IDX_W-1:0] idx2 [LANES],
    output logic [NPRED-1:0] clr_mask,
    output logic [NPRED-1:0] set_mask
);

    always_comb begin
        clr_mask = '0;
        set_mask = '0;
        for (int l = 0; l < LANES; l++) begin
            if (wr[l].we1) begin
                if (wr[l].v1) set_mask[idx1[l]] = 1'b1;
                else          clr_mask[idx1[l]] = 1'b1;
            end
            if (wr[l].we2) begin
                if (wr[l].v2) set_mask[idx2[l]] = 1'b1;
                else          clr_mask[idx2[l]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pcmp_unit.sv
module pcmp_unit
    import pcmp_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int DATA_W = 64,
    parameter int NPRED  = 64,
    localparam int IDX_W = $clog2(NPRED)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        op_valid,
    input  logic [3*LANES-1:0]      op_type,
    input  logic [2*LANES-1:0]      op_rel,
    input  logic [IDX_W*LANES-1:0]  op_qp,
    input  logic [IDX_W*LANES-1:0]  op_p1,
    input  logic [IDX_W*LANES-1:0]  op_p2,
    input  logic [DATA_W*LANES-1:0] op_a,
    input  logic [DATA_W*LANES-1:0] op_b,
    input  logic [LANES-1:0]        op_nat_a,
    input  logic [LANES-1:0]        op_nat_b,
    output logic [NPRED-1:0]        pred_o
);

    localparam logic [NPRED-1:0] PRED_RST = {{(NPRED-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [NPRED-1:0] pred;
    } state_t;

    state_t st_d, st_q;

    pwr_t             lane_wr [LANES];
    logic [IDX_W-1:0] lane_p1 [LANES];
    logic [IDX_W-1:0] lane_p2 [LANES];
    logic [NPRED-1:0] clr_mask;
    logic [NPRED-1:0] set_mask;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [IDX_W-1:0] qp_idx;
        assign qp_idx     = op_qp[l*IDX_W +: IDX_W];
        assign lane_p1[l] = op_p1[l*IDX_W +: IDX_W];
        assign lane_p2[l] = op_p2[l*IDX_W +: IDX_W];

        pcmp_lane #(.DATA_W(DATA_W)) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .valid  (op_valid[l]),
            .ctype  (ctype_e'(op_type[l*3 +: 3])),
            .rel    (rel_e'(op_rel[l*2 +: 2])),
            .a      (op_a[l*DATA_W +: DATA_W]),
            .b      (op_b[l*DATA_W +: DATA_W]),
            .nat    (op_nat_a[l] | op_nat_b[l]),
            .qp_val (st_q.pred[qp_idx]),
            .wr     (lane_wr[l])
        );
    end

    pcmp_merge #(.LANES(LANES), .NPRED(NPRED)) merge_i (
        .wr       (lane_wr),
        .idx1     (lane_p1),
        .idx2     (lane_p2),
        .clr_mask (clr_mask),
        .set_mask (set_mask)
    );

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NPRED; k++) begin
            if (k == 0)           st_d.pred[k] = 1'b1;
            else if (clr_mask[k]) st_d.pred[k] = 1'b0;
            else if (set_mask[k]) st_d.pred[k] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{pred: PRED_RST};
        else        st_q <= st_d;
    end

    assign pred_o = st_q.pred;

    assert_p0_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pred_o[0]);

    for (genvar k = 1; k < NPRED; k++) begin : g_chk
        assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            clr_mask[k] |=> !pred_o[k]);
        assert_set_lands_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (set_mask[k] && !clr_mask[k]) |=> pred_o[k]);
    end

endmodule

// File: tb/pcmp_unit_tb.sv
`timescale 1ns/1ps
module pcmp_unit_tb_top;

    localparam int LANES  = 3;
    localparam int DATA_W = 8;
    localparam int NPRED  = 64;
    localparam int IDX_W  = 6;
    localparam time TCK   = 20ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic [LANES-1:0]        op_valid;
    logic [3*LANES-1:0]      op_type;
    logic [2*LANES-1:0]      op_rel;
    logic [IDX_W*LANES-1:0]  op_qp, op_p1, op_p2;
    logic [DATA_W*LANES-1:0] op_a, op_b;
    logic [LANES-1:0]        op_nat_a, op_nat_b;
    logic [NPRED-1:0]        pred_o;

    logic             t_valid [LANES];
    logic [2:0]       t_type  [LANES];
    logic [1:0]       t_rel   [LANES];
    logic [IDX_W-1:0] t_qp    [LANES];
    logic [IDX_W-1:0] t_p1    [LANES];
    logic [IDX_W-1:0] t_p2    [LANES];
    logic [DATA_W-1:0] t_a    [LANES];
    logic [DATA_W-1:0] t_b    [LANES];
    logic             t_na    [LANES];
    logic             t_nb    [LANES];

    logic [NPRED-1:0] model;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(TCK/2) clk = ~clk;

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            op_valid[l]                 = t_valid[l];
            op_type[l*3 +: 3]           = t_type[l];
            op_rel[l*2 +: 2]            = t_rel[l];
            op_qp[l*IDX_W +: IDX_W]     = t_qp[l];
            op_p1[l*IDX_W +: IDX_W]     = t_p1[l];
            op_p2[l*IDX_W +: IDX_W]     = t_p2[l];
            op_a[l*DATA_W +: DATA_W]    = t_a[l];
            op_b[l*DATA_W +: DATA_W]    = t_b[l];
            op_nat_a[l]                 = t_na[l];
            op_nat_b[l]                 = t_nb[l];
        end
    end

    pcmp_unit #(.LANES(LANES), .DATA_W(DATA_W), .NPRED(NPRED)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_type(op_type),
        .op_rel(op_rel), .op_qp(op_qp), .op_p1(op_p1), .op_p2(op_p2),
        .op_a(op_a), .op_b(op_b), .op_nat_a(op_nat_a), .op_nat_b(op_nat_b),
        .pred_o(pred_o)
    );

    // expected next file from requirements R2..R12
    function automatic logic [NPRED-1:0] predict(input logic [NPRED-1:0] cur);
        logic [NPRED-1:0] clr = '0;
        logic [NPRED-1:0] set = '0;
        logic [NPRED-1:0] nxt;
        for (int l = 0; l < LANES; l++) begin
            logic r, nat, qp, w, v1, v2;
            if (!t_valid[l]) continue;
            case (t_rel[l])
                2'd0: r = (t_a[l] == t_b[l]);
                2'd1: r = (t_a[l] != t_b[l]);
                2'd2: r = ($signed(t_a[l]) < $signed(t_b[l]));
                default: r = (t_a[l] < t_b[l]);
            endcase
            nat = t_na[l] | t_nb[l];
            qp  = cur[t_qp[l]];
            w = 0; v1 = 0; v2 = 0;
            case (t_type[l])
                3'd0: if (qp) begin w = 1; v1 = nat ? 0 : r; v2 = nat ? 0 : !r; end
                3'd1: begin w = 1; if (qp && !nat) begin v1 = r; v2 = !r; end end
                3'd2: if (qp && (nat || !r)) begin w = 1; end
                3'd3: if (qp && !nat && r) begin w = 1; v1 = 1; v2 = 1; end
                3'd4: if (qp && (nat || !r)) begin w = 1; v2 = 1; end
                3'd5: if (qp && !nat && r) begin w = 1; v1 = 1; end
                default: w = 0;
            endcase
            if (w) begin
                if (v1) set[t_p1[l]] = 1; else clr[t_p1[l]] = 1;
                if (v2) set[t_p2[l]] = 1; else clr[t_p2[l]] = 1;
            end
        end
        nxt = (cur & ~clr) | (set & ~clr);
        nxt[0] = 1'b1;
        return nxt;
    endfunction

    task automatic clear_ops();
        for (int l = 0; l < LANES; l++) begin
            t_valid[l] = 0; t_type[l] = 0; t_rel[l] = 0; t_qp[l] = 0;
            t_p1[l] = 0; t_p2[l] = 0; t_a[l] = 0; t_b[l] = 0;
            t_na[l] = 0; t_nb[l] = 0;
        end
    endtask

    task automatic set_op(input int l, input logic [2:0] ty, input logic [1:0] rl,
                          input int qp, input int p1, input int p2,
                          input int a, input int b, input bit na, input bit nb);
        t_valid[l] = 1; t_type[l] = ty; t_rel[l] = rl;
        t_qp[l] = IDX_W'(qp); t_p1[l] = IDX_W'(p1); t_p2[l] = IDX_W'(p2);
        t_a[l] = DATA_W'(a); t_b[l] = DATA_W'(b); t_na[l] = na; t_nb[l] = nb;
    endtask

    // issue current ops, wait one edge, compare the file to the model
    task automatic cycle(input string req);
        logic [NPRED-1:0] exp;
        exp = predict(model);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (pred_o !== exp) begin
            errors++;
            $display("FAIL %s: pred_o=%h expected %h", req, pred_o, exp);
        end
        model = exp;
        clear_ops();
    endtask

    task automatic chk_bit(input string req, input int idx, input bit expv);
        checks++;
        if (pred_o[idx] !== expv) begin
            errors++;
            $display("FAIL %s: pred[%0d]=%b expected %b", req, idx, pred_o[idx], expv);
        end
    endtask

    initial begin
        #(TCK * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        clear_ops();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (pred_o !== 64'h1) begin
            errors++;
            $display("FAIL R1: pred_o=%h expected %h", pred_o, 64'h1);
        end
        model = 64'h1;

        // R2 relations
        set_op(0, 3'd0, 2'd0, 0, 3, 4, 5, 5, 0, 0); cycle("R2");
        chk_bit("R2", 3, 1); chk_bit("R2", 4, 0);
        set_op(0, 3'd0, 2'd2, 0, 5, 6, 8'h80, 1, 0, 0); cycle("R2");
        chk_bit("R2", 5, 1); chk_bit("R2", 6, 0);
        set_op(0, 3'd0, 2'd3, 0, 7, 8, 8'h80, 1, 0, 0); cycle("R2");
        chk_bit("R2", 7, 0); chk_bit("R2", 8, 1);
        set_op(0, 3'd6, 2'd0, 0, 9, 10, 1, 1, 0, 0); cycle("R2");
        chk_bit("R2", 9, 0); chk_bit("R2", 10, 0);

        // R9 false qualifier: pred7 is 0
        set_op(0, 3'd0, 2'd1, 7, 8, 3, 1, 1, 0, 0); cycle("R9");
        chk_bit("R9", 8, 1); chk_bit("R9", 3, 1);
        set_op(0, 3'd2, 2'd1, 7, 8, 3, 1, 1, 0, 0); cycle("R9");
        chk_bit("R9", 8, 1);

        // R3 unconditional with false qualifier clears
        set_op(0, 3'd1, 2'd0, 7, 3, 8, 1, 1, 0, 0); cycle("R3");
        chk_bit("R3", 3, 0); chk_bit("R3", 8, 0);

        // R4 NaT on normal / unconditional
        set_op(0, 3'd0, 2'd0, 0, 5, 6, 2, 2, 1, 0); cycle("R4");
        chk_bit("R4", 5, 0); chk_bit("R4", 6, 0);
        set_op(0, 3'd1, 2'd1, 0, 5, 6, 2, 3, 0, 1); cycle("R4");
        chk_bit("R4", 6, 0);

        // R6 then R5
        set_op(0, 3'd3, 2'd0, 0, 10, 11, 4, 4, 0, 0); cycle("R6");
        chk_bit("R6", 10, 1); chk_bit("R6", 11, 1);
        set_op(0, 3'd3, 2'd1, 0, 10, 11, 4, 4, 0, 0); cycle("R6");
        chk_bit("R6", 10, 1);
        set_op(0, 3'd2, 2'd0, 0, 10, 11, 4, 4, 0, 0); cycle("R5");
        chk_bit("R5", 10, 1); chk_bit("R5", 11, 1);
        set_op(0, 3'd2, 2'd1, 0, 10, 11, 4, 4, 0, 0); cycle("R5");
        chk_bit("R5", 10, 0); chk_bit("R5", 11, 0);

        // R7 complementary forms
        set_op(0, 3'd4, 2'd1, 0, 12, 13, 4, 4, 0, 0); cycle("R7");
        chk_bit("R7", 12, 0); chk_bit("R7", 13, 1);
        set_op(0, 3'd5, 2'd0, 0, 12, 13, 4, 4, 0, 0); cycle("R7");
        chk_bit("R7", 12, 1); chk_bit("R7", 13, 0);
        set_op(0, 3'd5, 2'd1, 0, 12, 13, 4, 4, 0, 0); cycle("R7");
        chk_bit("R7", 12, 1);

        // R8 NaT counts as false for parallel types
        set_op(0, 3'd3, 2'd0, 0, 14, 15, 1, 1, 0, 0); cycle("R8");
        set_op(0, 3'd2, 2'd0, 0, 14, 15, 1, 1, 1, 0); cycle("R8");
        chk_bit("R8", 14, 0); chk_bit("R8", 15, 0);
        set_op(0, 3'd3, 2'd0, 0, 14, 15, 1, 1, 0, 1); cycle("R8");
        chk_bit("R8", 14, 0);

        // R10 accumulation across lanes and conflict resolution
        set_op(0, 3'd3, 2'd1, 0, 20, 21, 1, 1, 0, 0);
        set_op(1, 3'd3, 2'd0, 0, 20, 21, 1, 1, 0, 0);
        set_op(2, 3'd3, 2'd1, 0, 20, 21, 1, 1, 0, 0); cycle("R10");
        chk_bit("R10", 20, 1); chk_bit("R10", 21, 1);
        set_op(0, 3'd2, 2'd0, 0, 20, 21, 1, 1, 0, 0);
        set_op(1, 3'd2, 2'd1, 0, 20, 21, 1, 1, 0, 0); cycle("R10");
        chk_bit("R10", 20, 0); chk_bit("R10", 21, 0);
        set_op(0, 3'd3, 2'd0, 0, 22, 23, 1, 1, 0, 0); cycle("R10");
        set_op(0, 3'd0, 2'd0, 0, 22, 23, 1, 1, 0, 0);
        set_op(1, 3'd0, 2'd0, 0, 23, 22, 1, 1, 0, 0); cycle("R10");
        chk_bit("R10", 22, 0); chk_bit("R10", 23, 0);

        // R11 predicate 0 fixed
        set_op(0, 3'd0, 2'd1, 0, 0, 24, 1, 1, 0, 0); cycle("R11");
        chk_bit("R11", 0, 1);
        set_op(0, 3'd1, 2'd0, 7, 0, 24, 1, 1, 0, 0); cycle("R11");
        chk_bit("R11", 0, 1);

        // R12 qualifier read before same-cycle write
        set_op(0, 3'd3, 2'd0, 0, 30, 31, 1, 1, 0, 0);
        set_op(1, 3'd0, 2'd0, 30, 32, 33, 1, 1, 0, 0); cycle("R12");
        chk_bit("R12", 30, 1); chk_bit("R12", 32, 0); chk_bit("R12", 33, 0);
        set_op(1, 3'd0, 2'd0, 30, 32, 33, 1, 1, 0, 0); cycle("R12");
        chk_bit("R12", 32, 1);

        // random mix over crowded low predicates
        for (int n = 0; n < 3000; n++) begin
            for (int l = 0; l < LANES; l++) begin
                if ($urandom_range(3) != 0) begin
                    set_op(l, 3'($urandom_range(7)), 2'($urandom_range(3)),
                           $urandom_range(15), $urandom_range(15), $urandom_range(15),
                           $urandom_range(7), $urandom_range(7) ^ ($urandom_range(1) << 7),
                           ($urandom_range(7) == 0), ($urandom_range(7) == 0));
                end
            end
            cycle("R2/R3/R4/R5/R6/R7/R8/R9/R10/R12");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule